// File: doc/BRIEF.md
# Conditional Branch and Jump Resolver

This block settles every control-flow decision of a core whose integer registers are 128 bits wide but whose datapath works on 64-bit halves. For a conditional branch it compares two 128-bit operands, each given as a low and a high half, under one of six conditions. It produces the branch target, the jump-and-link target, the register-indirect jump target and the return-address value. It also detects an instruction-address-misaligned fault. Decode feeds one instruction per valid cycle. The taken flag, the next PC and the link write come out combinationally in the same cycle.

The signed comparison uses a two-word subtraction with a borrow passed from the low half into the high half. An overflow correction term then fixes the sign. The unsigned comparison seeds a third word with one and lets the borrow chain decide. When the second source is the zero register, the equality and signed tests take a short path that uses only the first operand. The alignment fault is raised only when compressed instructions are off. A parameter chooses whether compressed support is fixed off, fixed on, or taken from a pin. The fault flag is a register. Each valid instruction overwrites it, and it holds its value in idle cycles.

Top module: `ctl_flow_unit`

## Requirements
- R1: With `kind_i`=01 (branch), `cond_i` selects the test on A={a_hi_i,a_lo_i} against B={b_hi_i,b_lo_i}: 000 equal, 001 not equal, 100 signed less, 101 signed greater-or-equal, 110 unsigned less, 111 unsigned greater-or-equal. `taken_o` is the result. Codes 010 and 011 are never taken.
- R2: Signed tests give the correct result when the low halves produce a borrow and when the 128-bit difference overflows.
- R3: When `b_zero_i` is 1, the B inputs have no effect, and every condition compares A against zero.
- R4: When the instruction is not taken, `next_pc_o` is `pc_i`+4 if `ilen4_i`=1 and `pc_i`+2 otherwise.
- R5: A taken branch and a jump-and-link (`kind_i`=10) go to `pc_i`+`imm_i`, with `taken_o`=1.
- R6: A register jump (`kind_i`=11) goes to (`a_lo_i`+`imm_i`) with bit 0 cleared, with `taken_o`=1.
- R7: For kinds 10 and 11, `link_o` is the sequential address of R4. `link_we_o` is 1 only when `rd_i` is nonzero and no fault is raised.
- R8: When compressed support is off, a fault is raised in three cases: a taken branch or a jump-and-link whose target has bit 1 or bit 0 set, and a register jump whose target has bit 1 set. A branch that is not taken never faults.
- R9: When compressed support is on, no fault is raised.
- R10: `misalign_o` is 0 after reset. In the cycle after each valid instruction it shows that instruction's fault status, and it holds its value while `valid_i` is 0.
- R11: `kind_i`=00, or `valid_i`=0, gives `taken_o`=0 and `link_we_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction present this cycle |
| kind_i | input | 2 | 00 other, 01 branch, 10 jump-and-link, 11 register jump |
| cond_i | input | 3 | Branch condition code |
| a_lo_i | input | 64 | First operand, low half |
| a_hi_i | input | 64 | First operand, high half |
| b_lo_i | input | 64 | Second operand, low half |
| b_hi_i | input | 64 | Second operand, high half |
| b_zero_i | input | 1 | Second source is the zero register |
| pc_i | input | 64 | Address of the instruction |
| imm_i | input | 64 | Sign-extended offset |
| ilen4_i | input | 1 | 1: 4-byte instruction, 0: 2-byte |
| rvc_en_i | input | 1 | Compressed support enabled |
| rd_i | input | 5 | Destination register index |
| taken_o | output | 1 | Control transfer taken |
| next_pc_o | output | 64 | Address of the next instruction |
| link_o | output | 64 | Return address to write |
| link_we_o | output | 1 | Return-address write enable |
| misalign_o | output | 1 | Registered misaligned-target fault |

## Verification
A link write and a misalignment fault can be requested by the same jump. When the target is misaligned and compressed support is off, the fault must suppress the write. The bench provokes this with a register jump whose sum has bit 1 set and a nonzero destination. It expects `link_we_o` low in that cycle and `misalign_o` high one clock later. The same instruction is then repeated with compressed support on, and the bench expects the write and no fault.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
   typedef enum logic [1:0] {
      K_SEQ  = 2'b00,
      K_BR   = 2'b01,
      K_JAL  = 2'b10,
      K_JALR = 2'b11
   } kind_e;

   localparam logic [2:0] C_EQ  = 3'b000;
   localparam logic [2:0] C_NE  = 3'b001;
   localparam logic [2:0] C_LT  = 3'b100;
   localparam logic [2:0] C_GE  = 3'b101;
   localparam logic [2:0] C_LTU = 3'b110;
   localparam logic [2:0] C_GEU = 3'b111;
endpackage

// File: rtl/cf_cmp128.sv
module cf_cmp128 #(
   parameter int HW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [HW-1:0] a_lo,
   input  logic [HW-1:0] a_hi,
   input  logic [HW-1:0] b_lo_raw,
   input  logic [HW-1:0] b_hi_raw,
   input  logic          b_zero,
   input  logic [2:0]    cond,
   output logic          hit
);
   import ctl_pkg::*;

   logic [HW-1:0] b_lo, b_hi;
   logic [HW-1:0] zsum, d_lo, d_hi, corr;
   logic          bor_lo, is_eq, lt_s, ge_u;
   logic [HW:0]   third;

   assign b_lo = b_zero ? '0 : b_lo_raw;
   assign b_hi = b_zero ? '0 : b_hi_raw;

   // equality: fold both halves to one word, zero means equal
   assign zsum  = b_zero ? (a_lo | a_hi) : ((a_lo ^ b_lo) | (a_hi ^ b_hi));
   assign is_eq = (zsum == '0);

   // signed: two-word subtraction with overflow correction
   assign {bor_lo, d_lo} = {1'b0, a_lo} - {1'b0, b_lo};
   assign d_hi = a_hi - b_hi - HW'(bor_lo);
   assign corr = (d_hi ^ a_hi) & (a_hi ^ b_hi);
   assign lt_s = b_zero ? a_hi[HW-1] : (d_hi ^ corr) & {1'b1, {(HW-1){1'b0}}} ? 1'b1 : 1'b0;

   // unsigned: borrow chain into a third word seeded with one
   assign third = {1'b1, a_hi} - {1'b0, b_hi} - (HW+1)'(bor_lo);
   assign ge_u  = third[HW];

   always_comb begin
      unique case (cond)
         C_EQ:    hit = is_eq;
         C_NE:    hit = !is_eq;
         C_LT:    hit = lt_s;
         C_GE:    hit = !lt_s;
         C_LTU:   hit = !ge_u;
         C_GEU:   hit = ge_u;
         default: hit = 1'b0;
      endcase
   end

   // R1: equal operands are neither signed-less nor unsigned-less
   a_r1_eq_not_less: assert property (@(posedge clk) disable iff (!rst_n)
      is_eq |-> (!lt_s && ge_u));
   // R2: sign of a zero-valued b with overflow-free path matches a's sign
   a_r2_zero_b_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (b_lo == '0 && b_hi == '0) |-> (lt_s == a_hi[HW-1]));
endmodule

// File: rtl/cf_target.sv
module cf_target #(
   parameter int PW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    kind,
   input  logic [PW-1:0] pc,
   input  logic [PW-1:0] imm,
   input  logic [PW-1:0] base,
   input  logic          ilen4,
   output logic [PW-1:0] seq_pc,
   output logic [PW-1:0] jump_pc
);
   import ctl_pkg::*;

   logic [PW-1:0] rel_sum, reg_sum;

   assign seq_pc  = pc + (ilen4 ? PW'(4) : PW'(2));
   assign rel_sum = pc + imm;
   assign reg_sum = base + imm;
   assign jump_pc = (kind == K_JALR) ? {reg_sum[PW-1:1], 1'b0} : rel_sum;

   // R6: register jump target is always even
   a_r6_even_target: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == K_JALR) |-> !jump_pc[0]);
   // R4: sequential address advances by a legal instruction length
   a_r4_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_pc - pc == PW'(4)) || (seq_pc - pc == PW'(2)));
endmodule

// File: rtl/ctl_flow_unit.sv
module ctl_flow_unit #(
   parameter int HW     = 64,
   parameter int PW     = 64,
   parameter int C_MODE = 2   // 0 never compressed, 1 always, 2 from pin
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          valid_i,
   input  logic [1:0]    kind_i,
   input  logic [2:0]    cond_i,
   input  logic [HW-1:0] a_lo_i,
   input  logic [HW-1:0] a_hi_i,
   input  logic [HW-1:0] b_lo_i,
   input  logic [HW-1:0] b_hi_i,
   input  logic          b_zero_i,
   input  logic [PW-1:0] pc_i,
   input  logic [PW-1:0] imm_i,
   input  logic          ilen4_i,
   input  logic          rvc_en_i,
   input  logic [4:0]    rd_i,
   output logic          taken_o,
   output logic [PW-1:0] next_pc_o,
   output logic [HW-1:0] link_o,
   output logic          link_we_o,
   output logic          misalign_o
);
   import ctl_pkg::*;

   initial begin
      if (HW < 8) $error("HW too small");
      if (PW < 8 || PW > HW) $error("PW must be 8..HW");
      if (C_MODE < 0 || C_MODE > 2) $error("C_MODE must be 0..2");
   end

   logic          hit, c_ok, is_jump, mis_c, misalign_q;
   logic [PW-1:0] seq_pc, jump_pc;

   generate
      if (C_MODE == 0) begin : g_c_off
         assign c_ok = 1'b0;
      end else if (C_MODE == 1) begin : g_c_on
         assign c_ok = 1'b1;
      end else begin : g_c_pin
         assign c_ok = rvc_en_i;
      end
   endgenerate

   cf_cmp128 #(.HW(HW)) u_cmp (
      .clk(clk), .rst_n(rst_n),
      .a_lo(a_lo_i), .a_hi(a_hi_i), .b_lo_raw(b_lo_i), .b_hi_raw(b_hi_i),
      .b_zero(b_zero_i), .cond(cond_i), .hit(hit)
   );

   cf_target #(.PW(PW)) u_tgt (
      .clk(clk), .rst_n(rst_n),
      .kind(kind_i), .pc(pc_i), .imm(imm_i), .base(a_lo_i[PW-1:0]),
      .ilen4(ilen4_i), .seq_pc(seq_pc), .jump_pc(jump_pc)
   );

   assign is_jump = (kind_i == K_JAL) || (kind_i == K_JALR);
   assign taken_o = valid_i && (is_jump || (kind_i == K_BR && hit));

   always_comb begin
      mis_c = 1'b0;
      if (valid_i && !c_ok) begin
         if (kind_i == K_JALR)
            mis_c = jump_pc[1];
         else if (kind_i == K_JAL || (kind_i == K_BR && hit))
            mis_c = |jump_pc[1:0];
      end
   end

   assign next_pc_o = taken_o ? jump_pc : seq_pc;
   assign link_o    = HW'(seq_pc);
   assign link_we_o = valid_i && is_jump && (rd_i != 5'd0) && !mis_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       misalign_q <= 1'b0;
      else if (valid_i) misalign_q <= mis_c;
   end
   assign misalign_o = misalign_q;

   // R7: no link write to the zero register
   a_r7_no_x0_write: assert property (@(posedge clk) disable iff (!rst_n)
      link_we_o |-> (rd_i != 5'd0));
   // R10: fault register follows each valid instruction
   a_r10_fault_update: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> (misalign_o == $past(mis_c)));
   // R10: fault register holds when idle
   a_r10_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> $stable(misalign_o));
   // R9: compressed support suppresses the fault
   a_r9_c_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && c_ok) |=> !misalign_o);
   // R4: not-taken path continues sequentially
   a_r4_not_taken_seq: assert property (@(posedge clk) disable iff (!rst_n)
      !taken_o |-> (next_pc_o == seq_pc));
   // R11: idle or other instruction never transfers control
   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_i || kind_i == K_SEQ) |-> (!taken_o && !link_we_o));
endmodule

// File: tb/sim_ctl_flow_unit.sv
module sim_ctl_flow_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [1:0]  kind_i = '0;
   logic [2:0]  cond_i = '0;
   logic [63:0] a_lo_i = '0, a_hi_i = '0, b_lo_i = '0, b_hi_i = '0;
   logic        b_zero_i = 1'b0;
   logic [63:0] pc_i = '0, imm_i = '0;
   logic        ilen4_i = 1'b1, rvc_en_i = 1'b0;
   logic [4:0]  rd_i = '0;
   logic        taken_o, link_we_o, misalign_o;
   logic [63:0] next_pc_o, link_o;

   int errors = 0;
   int checks = 0;

   always #5 clk = ~clk;

   ctl_flow_unit u0 (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .kind_i(kind_i),
      .cond_i(cond_i), .a_lo_i(a_lo_i), .a_hi_i(a_hi_i), .b_lo_i(b_lo_i),
      .b_hi_i(b_hi_i), .b_zero_i(b_zero_i), .pc_i(pc_i), .imm_i(imm_i),
      .ilen4_i(ilen4_i), .rvc_en_i(rvc_en_i), .rd_i(rd_i),
      .taken_o(taken_o), .next_pc_o(next_pc_o), .link_o(link_o),
      .link_we_o(link_we_o), .misalign_o(misalign_o)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive one instruction, check comb outputs, then the registered fault
   task automatic run(input string tag, input logic [1:0] k, input logic [2:0] c,
                      input logic [63:0] al, input logic [63:0] ah,
                      input logic [63:0] bl, input logic [63:0] bh, input logic bz,
                      input logic [63:0] pc, input logic [63:0] imm,
                      input logic l4, input logic rvc, input logic [4:0] rd);
      logic [127:0] A, B;
      logic         hit, tk, mis, we;
      logic [63:0]  tgt, sq;
      A = {ah, al};
      B = bz ? 128'd0 : {bh, bl};
      case (c)
         3'b000: hit = (A == B);
         3'b001: hit = (A != B);
         3'b100: hit = ($signed(A) < $signed(B));
         3'b101: hit = ($signed(A) >= $signed(B));
         3'b110: hit = (A < B);
         3'b111: hit = (A >= B);
         default: hit = 1'b0;
      endcase
      sq  = pc + (l4 ? 64'd4 : 64'd2);
      tgt = (k == 2'b11) ? ((al + imm) & ~64'd1) : (pc + imm);
      tk  = (k == 2'b10) || (k == 2'b11) || (k == 2'b01 && hit);
      mis = !rvc && ((k == 2'b11 && tgt[1]) ||
                     ((k == 2'b10 || (k == 2'b01 && hit)) && tgt[1:0] != 2'b00));
      we  = (k[1] == 1'b1) && rd != 5'd0 && !mis;
      @(negedge clk);
      valid_i = 1'b1; kind_i = k; cond_i = c; a_lo_i = al; a_hi_i = ah;
      b_lo_i = bl; b_hi_i = bh; b_zero_i = bz; pc_i = pc; imm_i = imm;
      ilen4_i = l4; rvc_en_i = rvc; rd_i = rd;
      #2;
      chk({tag, " taken"}, 64'(tk), 64'(taken_o));
      chk({tag, " next_pc"}, next_pc_o, tk ? tgt : sq);
      if (k[1]) chk({tag, " link"}, link_o, sq);
      chk({tag, " link_we"}, 64'(link_we_o), 64'(we));
      @(posedge clk); #1;
      chk({tag, " misalign"}, 64'(misalign_o), 64'(mis));
      valid_i = 1'b0;
   endtask

   task automatic t_reset;
      #1;
      chk("R10 reset misalign", 64'(misalign_o), 64'd0);
      chk("R11 idle taken", 64'(taken_o), 64'd0);
   endtask

   task automatic t_equality;
      run("R1 beq equal", 2'b01, 3'b000, 64'h55, 64'h9, 64'h55, 64'h9, 0, 64'h100, 64'h40, 1, 0, 0);
      run("R1 beq hi differs", 2'b01, 3'b000, 64'h55, 64'h9, 64'h55, 64'h8, 0, 64'h100, 64'h40, 1, 0, 0);
      run("R1 bne hi differs", 2'b01, 3'b001, 64'h55, 64'h9, 64'h55, 64'h8, 0, 64'h100, 64'h40, 1, 0, 0);
      run("R1 undefined cond", 2'b01, 3'b010, 64'h1, 64'h0, 64'h1, 64'h0, 0, 64'h100, 64'h40, 1, 0, 0);
   endtask

   task automatic t_order;
      run("R1 blt neg", 2'b01, 3'b100, '1, '1, 64'h0, 64'h0, 0, 64'h200, 64'h10, 1, 0, 0);
      run("R1 bltu neg", 2'b01, 3'b110, '1, '1, 64'h0, 64'h0, 0, 64'h200, 64'h10, 1, 0, 0);
      run("R1 bgeu big", 2'b01, 3'b111, '1, '1, 64'h5, 64'h0, 0, 64'h200, 64'h10, 1, 0, 0);
      run("R2 overflow min<1", 2'b01, 3'b100, 64'h0, 64'h8000_0000_0000_0000, 64'h1, 64'h0, 0, 64'h200, 64'h10, 1, 0, 0);
      run("R2 overflow max>=-1", 2'b01, 3'b101, '1, 64'h7fff_ffff_ffff_ffff, '1, '1, 0, 64'h200, 64'h10, 1, 0, 0);
      run("R2 low borrow ge", 2'b01, 3'b101, 64'h0, 64'h1, 64'h1, 64'h0, 0, 64'h200, 64'h10, 1, 0, 0);
      run("R1 low borrow geu", 2'b01, 3'b111, 64'h0, 64'h1, 64'h1, 64'h0, 0, 64'h200, 64'h10, 1, 0, 0);
      run("R1 low borrow ltu", 2'b01, 3'b110, 64'h0, 64'h1, 64'h1, 64'h1, 0, 64'h200, 64'h10, 1, 0, 0);
   endtask

   task automatic t_zero_src;
      run("R3 beq x0 nonzero a", 2'b01, 3'b000, 64'h5, 64'h0, 64'h5, 64'h0, 1, 64'h300, 64'h8, 1, 0, 0);
      run("R3 beq x0 zero a", 2'b01, 3'b000, 64'h0, 64'h0, 64'hdead, 64'hbeef, 1, 64'h300, 64'h8, 1, 0, 0);
      run("R3 blt x0 positive", 2'b01, 3'b100, 64'h5, 64'h0, 64'h9, 64'h7, 1, 64'h300, 64'h8, 1, 0, 0);
      run("R3 bgeu x0", 2'b01, 3'b111, 64'h0, 64'h0, '1, '1, 1, 64'h300, 64'h8, 1, 0, 0);
   endtask

   task automatic t_jumps;
      run("R5 R7 jal", 2'b10, 3'b000, 64'h0, 64'h0, 64'h0, 64'h0, 0, 64'h1000, 64'h20, 1, 0, 5'd1);
      run("R7 jal rd0", 2'b10, 3'b000, 64'h0, 64'h0, 64'h0, 64'h0, 0, 64'h1000, 64'hffff_ffff_ffff_fff0, 1, 0, 5'd0);
      run("R6 jalr clear bit0", 2'b11, 3'b000, 64'h2003, 64'h0, 64'h0, 64'h0, 0, 64'h1000, 64'h2, 1, 0, 5'd3);
   endtask

   task automatic t_fault_and_link;
      run("R8 jalr bit1 no link", 2'b11, 3'b000, 64'h2001, 64'h0, 64'h0, 64'h0, 0, 64'h1000, 64'h1, 1, 0, 5'd4);
      run("R9 jalr bit1 with C", 2'b11, 3'b000, 64'h2001, 64'h0, 64'h0, 64'h0, 0, 64'h1000, 64'h1, 0, 1, 5'd4);
      run("R8 branch taken odd", 2'b01, 3'b000, 64'h1, 64'h0, 64'h1, 64'h0, 0, 64'h100, 64'h6, 1, 0, 0);
      run("R8 branch not taken", 2'b01, 3'b001, 64'h1, 64'h0, 64'h1, 64'h0, 0, 64'h100, 64'h6, 1, 0, 0);
      run("R8 jal bit0", 2'b10, 3'b000, 64'h0, 64'h0, 64'h0, 64'h0, 0, 64'h100, 64'h5, 1, 0, 5'd2);
      run("R9 branch odd with C", 2'b01, 3'b000, 64'h1, 64'h0, 64'h1, 64'h0, 0, 64'h100, 64'h6, 0, 1, 0);
   endtask

   task automatic t_hold;
      run("R10 raise", 2'b10, 3'b000, 64'h0, 64'h0, 64'h0, 64'h0, 0, 64'h100, 64'h2, 1, 0, 5'd1);
      @(negedge clk);
      kind_i = 2'b10; imm_i = 64'h8; rvc_en_i = 1'b1;
      @(posedge clk); #1;
      chk("R10 hold while idle", 64'(misalign_o), 64'd1);
      chk("R11 idle no link", 64'(link_we_o), 64'd0);
      run("R4 R11 other kind", 2'b00, 3'b000, 64'h0, 64'h0, 64'h0, 64'h0, 0, 64'h400, 64'h8, 0, 0, 5'd6);
      chk("R10 cleared by next valid", 64'(misalign_o), 64'd0);
   endtask

   initial begin
      fork
         begin
            t_reset();
            #12 rst_n = 1'b1;
            t_equality();
            t_order();
            t_zero_src();
            t_jumps();
            t_fault_and_link();
            t_hold();
         end
         begin
            repeat (5000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog expired");
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule